// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Block

This block holds the interrupt state of a USB host controller: a status register that collects hardware events, and one enable mask that software can change through two separate addresses. One address sets mask bits and the other clears them. Each event source has a single-cycle pulse input. A pulse latches the matching status bit. The bit stays set until software writes a one to it.

The block has one level interrupt output. The output is high while the top bit of the enable mask (the master gate) is set and at least one latched status bit also has its enable bit set. Software reaches the block through a plain register port: a write strobe, a read strobe, a 2-bit word select and 32-bit data. Read data is registered.

Word select map: 0 is the status register, 1 is the enable-set address, 2 is the enable-clear address, and 3 is reserved. Event input index k maps to status and enable bit positions 0, 1, 2, 3, 4, 5, 6 and 30 for k = 0 to 7. These are, in order: scheduling overrun, done-list write-back, start of frame, resume detected, unrecoverable error, frame counter overflow, root port change and ownership change. Enable bit 31 is the master gate.

Top module: `usb_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register and the enable mask are zero, `irq_o` is low and `reg_rdata` is zero.
- R2: A one-cycle pulse on `evt_pulse[k]` sets the status bit at the position mapped to k (0..6 for k=0..6, 30 for k=7). The bit is visible from the next clock edge and stays set while no clear reaches it.
- R3: A write to word 0 clears each status bit written as one and leaves each bit written as zero unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to word 1 sets each implemented enable bit written as one (bits 0..6, 30 and 31). Bits written as zero keep their value.
- R6: A write to word 2 clears each enable bit written as one. Bits written as zero keep their value.
- R7: Reads of word 1 and word 2 both return the current enable mask.
- R8: `irq_o` is high exactly when enable bit 31 is set and some status bit is set whose enable bit is also set. It follows the registers with no extra delay.
- R9: Bit positions 7..29 of both registers, and status bit 31, always read as zero and ignore writes. Writes to word 3 change nothing, and reads of word 3 return zero.
- R10: `reg_rdata` loads the selected word at the clock edge where `reg_rd_en` is high. It holds its value while `reg_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word select (0 status, 1 enable set, 2 enable clear, 3 reserved) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 8 | Single-cycle event pulses, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
A write or an event pulse that is sampled at a rising edge changes the registers at that edge. `irq_o` follows from the register outputs through gates only, so it is already valid in the half cycle after that edge. A read strobe sampled at an edge places the data on `reg_rdata` at the same edge. The bench therefore drives every input at a falling edge and samples every result at the next falling edge, one register stage later. For the read-hold case it changes state without a strobe and confirms that the old read data is still present afterwards.

// File: rtl/usb_irq_pkg.sv
// Package: shared constants for the USB interrupt status and enable block.
// Assumes a 32-bit register word and eight event sources at fixed bit positions.
package usb_irq_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2;
    localparam int NUM_SRC    = 8;
    localparam int MASTER_BIT = 31;

    // Status and enable bit position used by each event source index
    localparam int unsigned SRC_BIT [NUM_SRC] = '{0, 1, 2, 3, 4, 5, 6, 30};

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS = 2'd0,
        SEL_EN_SET = 2'd1,
        SEL_EN_CLR = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    // Builds the mask of bit positions that belong to event sources
    function automatic logic [DATA_W-1:0] build_src_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[SRC_BIT[i]] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] SRC_MASK    = build_src_mask();
    localparam logic [DATA_W-1:0] MASTER_MASK = DATA_W'(1) << MASTER_BIT;
    localparam logic [DATA_W-1:0] EN_MASK     = SRC_MASK | MASTER_MASK;

endpackage

// File: rtl/usb_irq_status_bank.sv
// Module: status register. Event pulses set bits and software clears them by writing ones.
// Assumes: event inputs are single-cycle pulses. An event beats a clear that arrives
// in the same cycle. Only source positions are stored, and all other bits stay zero.
module usb_irq_status_bank
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status_q
);

    logic [DATA_W-1:0] evt_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] status_d;

    // Scatter the event pulses onto their register bit positions
    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            evt_vec[SRC_BIT[i]] = evt_pulse[i];
        end
    end

    // Apply the write-one clear first, then let events override it
    always_comb begin
        clr_vec  = clr_we ? wdata : '0;
        status_d = ((status_q & ~clr_vec) | evt_vec) & SRC_MASK;
    end

    // Status storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Per-source checks on set, clear and hold behaviour
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
        localparam int P = SRC_BIT[i];

        p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_pulse[i] |=> status_q[P]);

        p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && wdata[P] && !evt_pulse[i]) |=> !status_q[P]);

        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_pulse[i] && !(clr_we && wdata[P])) |=> $stable(status_q[P]));

        p_evt_beats_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_pulse[i] && clr_we && wdata[P]) |=> status_q[P]);
    end

endmodule

// File: rtl/usb_irq_enable_bank.sv
// Module: shared enable mask that software changes through a set address and a clear address.
// Assumes: set and clear never arrive together, because they share one write port.
// Only source bits and the master bit are stored.
module usb_irq_enable_bank
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);

    logic [DATA_W-1:0] en_d;

    // Next mask: OR in the set bits, remove the clear bits, keep implemented bits only
    always_comb begin
        en_d = ((en_q | (set_we ? wdata : '0)) & ~(clr_we ? wdata : '0)) & EN_MASK;
    end

    // Mask storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // Per-bit checks on the implemented enable positions
    for (genvar b = 0; b < DATA_W; b++) begin : g_en_chk
        if (EN_MASK[b]) begin : g_impl
            p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (set_we && wdata[b]) |=> en_q[b]);

            p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && wdata[b]) |=> !en_q[b]);

            p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !((set_we || clr_we) && wdata[b]) |=> $stable(en_q[b]));
        end
    end

endmodule

// File: rtl/usb_irq_reg_port.sv
// Module: register port. Decodes the write strobes and registers the read data.
// Assumes: a one-word select per access. A read returns data one edge after the strobe.
module usb_irq_reg_port
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] en_q,
    output logic              status_clr_we,
    output logic              en_set_we,
    output logic              en_clr_we,
    output logic [DATA_W-1:0] rdata_q
);

    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_mux;

    // Select decode for writes
    always_comb begin
        sel           = reg_sel_e'(addr);
        status_clr_we = wr_en && (sel == SEL_STATUS);
        en_set_we     = wr_en && (sel == SEL_EN_SET);
        en_clr_we     = wr_en && (sel == SEL_EN_CLR);
    end

    // Read mux: both enable addresses return the same mask
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_mux = status_q;
            SEL_EN_SET: rd_mux = en_q;
            SEL_EN_CLR: rd_mux = en_q;
            default:    rd_mux = '0;
        endcase
    end

    // Read data register: loads on a strobe and holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_q));

    p_rd_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ((rdata_q & ~EN_MASK) == '0));

    p_rsvd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == SEL_RSVD) |=> (rdata_q == '0));

endmodule

// File: rtl/usb_irq_ctrl.sv
// Module: top of the USB host interrupt status and enable block.
// Combines the status bank, the enable bank and the register port, and forms the
// level interrupt from the stored registers with gates only.
// Assumes: a synchronous active-low reset and single-cycle event pulses.
module usb_irq_ctrl
    import usb_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic               irq_o
);

    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] en_q;
    logic              status_clr_we;
    logic              en_set_we;
    logic              en_clr_we;

    usb_irq_reg_port u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (reg_wr_en),
        .rd_en         (reg_rd_en),
        .addr          (reg_addr),
        .status_q      (status_q),
        .en_q          (en_q),
        .status_clr_we (status_clr_we),
        .en_set_we     (en_set_we),
        .en_clr_we     (en_clr_we),
        .rdata_q       (reg_rdata)
    );

    usb_irq_status_bank u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .clr_we    (status_clr_we),
        .wdata     (reg_wdata),
        .status_q  (status_q)
    );

    usb_irq_enable_bank u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (en_set_we),
        .clr_we (en_clr_we),
        .wdata  (reg_wdata),
        .en_q   (en_q)
    );

    // Interrupt level: master gate AND any enabled pending source
    always_comb begin
        irq_o = en_q[MASTER_BIT] && ((status_q & en_q & SRC_MASK) != '0);
    end

    p_master_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[MASTER_BIT] |-> !irq_o);

    p_no_pending_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq_o);

    p_status_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == SEL_RSVD && evt_pulse == '0) |=> $stable(status_q) && $stable(en_q));

endmodule

// File: tb/usb_irq_ctrl_bench.sv
module usb_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_irq_ctrl u_usb_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One write, optionally with event pulses in the same cycle
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [7:0] ev = '0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; evt_pulse = ev;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0; evt_pulse = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        evt_pulse = 8'(1) << k;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 rdata after reset", reg_rdata, 32'h0);
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        rd(2'd0, v); check("R1 status after reset", v, 32'h0);
        rd(2'd1, v); check("R1 mask after reset", v, 32'h0);
    endtask

    task automatic t_event_capture();
        logic [31:0] v;
        pulse(2);
        rd(2'd0, v); check("R2 start-of-frame latched", v, 32'h0000_0004);
        repeat (5) @(negedge clk);
        rd(2'd0, v); check("R2 bit held", v, 32'h0000_0004);
        pulse(7);
        rd(2'd0, v); check("R2 ownership bit 30", v, 32'h4000_0004);
    endtask

    task automatic t_status_w1c();
        logic [31:0] v;
        wr(2'd0, 32'h0);
        rd(2'd0, v); check("R3 zero write no effect", v, 32'h4000_0004);
        wr(2'd0, 32'h4);
        rd(2'd0, v); check("R3 single clear", v, 32'h4000_0000);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R3 clear all", v, 32'h0);
    endtask

    task automatic t_event_beats_clear();
        logic [31:0] v;
        wr(2'd0, 32'h1, 8'h01);
        rd(2'd0, v); check("R4 event wins over clear", v, 32'h1);
        wr(2'd0, 32'h1);
        rd(2'd0, v); check("R4 later clear works", v, 32'h0);
    endtask

    task automatic t_enable_set_clear();
        logic [31:0] v;
        wr(2'd1, 32'h8000_0041);
        rd(2'd1, v); check("R5 set bits", v, 32'h8000_0041);
        rd(2'd2, v); check("R7 clear addr reads mask", v, 32'h8000_0041);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R5 zero set no effect", v, 32'h8000_0041);
        wr(2'd2, 32'h1);
        rd(2'd2, v); check("R6 clear bit 0", v, 32'h8000_0040);
        rd(2'd1, v); check("R7 set addr reads mask", v, 32'h8000_0040);
        wr(2'd2, 32'h0);
        rd(2'd1, v); check("R6 zero clear no effect", v, 32'h8000_0040);
    endtask

    task automatic t_irq_gating();
        logic [31:0] v;
        check("R8 idle no irq", {31'b0, irq_o}, 32'h0);
        pulse(6);
        check("R8 enabled source raises irq", {31'b0, irq_o}, 32'h1);
        wr(2'd2, 32'h8000_0000);
        check("R8 master off drops irq", {31'b0, irq_o}, 32'h0);
        wr(2'd1, 32'h8000_0000);
        check("R8 master on restores irq", {31'b0, irq_o}, 32'h1);
        wr(2'd0, 32'h40);
        check("R8 clear drops irq", {31'b0, irq_o}, 32'h0);
        pulse(0);
        check("R8 disabled source no irq", {31'b0, irq_o}, 32'h0);
        rd(2'd0, v); check("R8 disabled source still latched", v, 32'h1);
        wr(2'd0, 32'h1);
    endtask

    task automatic t_unused_bits();
        logic [31:0] v;
        wr(2'd1, 32'h3FFF_FF80);
        rd(2'd1, v); check("R9 unused enable bits ignored", v, 32'h8000_0040);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R9 reserved write leaves status", v, 32'h0);
        rd(2'd1, v); check("R9 reserved write leaves mask", v, 32'h8000_0040);
        rd(2'd3, v); check("R9 reserved reads zero", v, 32'h0);
    endtask

    task automatic t_read_hold();
        logic [31:0] v;
        rd(2'd1, v); check("R10 read mask", v, 32'h8000_0040);
        wr(2'd1, 32'h1);
        @(negedge clk);
        check("R10 rdata holds without strobe", reg_rdata, 32'h8000_0040);
        rd(2'd1, v); check("R10 new read loads", v, 32'h8000_0041);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_event_capture();
        t_status_w1c();
        t_event_beats_clear();
        t_enable_set_clear();
        t_irq_gating();
        t_unused_bits();
        t_read_hold();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule